// File: doc/BRIEF.md
# Output Compare Waveform Generator

This timer channel drives a single output pin from a free-running period counter. The counter advances on a prescaler tick while the channel is enabled. When the count reaches the programmed period it wraps to zero, which is a compare event. Each compare event pulses a one-clock strobe. It also acts on the pin according to a two-bit output type: force low, positive pulse, negative pulse or toggle.

For the two pulse types, the pulse length is counted in undivided system clocks, not prescaled ticks. The pulse begins with the compare event and runs into the following period without stretching it. While the channel is disabled, the counter holds at zero and the pin follows a preset level. That preset level is also the starting level for toggle mode.

Top module: `ocw_gen`

## Requirements
- R1: While `en_i` is high, the counter advances by one on each clock where `tick_i` is high. A tick that finds the count at or above `period_i` wraps the count to zero. `evt_o` is high for exactly the one clock after that tick.
- R2: While `en_i` is low, the counter is held at zero, `evt_o` stays low, no pulse is active and `pin_o` equals `preset_i`.
- R3: With `otype_i` = 2'b00 and `en_i` high, `pin_o` is low on every clock, whatever the compare events.
- R4: With `otype_i` = 2'b01, `pin_o` rests low. A compare event drives it high for `pwidth_i` clocks, starting in the clock where `evt_o` is high.
- R5: With `otype_i` = 2'b10, `pin_o` rests high. A compare event drives it low for `pwidth_i` clocks, starting in the clock where `evt_o` is high.
- R6: The pulse length is counted in clocks and does not depend on how often `tick_i` is high.
- R7: With `pwidth_i` = 0, a compare event produces no pulse.
- R8: A compare event that occurs during a pulse ends that pulse and starts a fresh one of `pwidth_i` clocks. With a width longer than the period, the pin therefore stays at its active level.
- R9: With `otype_i` = 2'b11, `pin_o` inverts at each compare event. Toggling starts from the `preset_i` level held while the channel was disabled.
- R10: Compare events are `period_i`+1 ticks apart, whatever the pulse width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| tick_i | input | 1 | Prescaler tick, one clock wide |
| period_i | input | 16 | Compare terminal count |
| otype_i | input | 2 | Output action type (00 low, 01 high pulse, 10 low pulse, 11 toggle) |
| pwidth_i | input | 8 | Pulse width in clocks |
| preset_i | input | 1 | Pin level while disabled; starting level for toggle |
| evt_o | output | 1 | Compare event strobe |
| pin_o | output | 1 | Output pin level |

## Verification
Some properties are checked on every cycle. A strobe is always preceded by an enabled tick and always coincides with a zero count. The count holds between ticks. Disabling clears the counter, the strobe and the pulse. A nonzero width always starts a pulse and a zero width never does. The toggle state flips on each event and reloads the preset while disabled. Pulse lengths under slow ticks, event spacing under long pulses, retriggering and the pin level in each output type are whole-waveform behaviours. Only the bench scenarios show them, by comparing each clock against a reference model and by measuring run lengths directly.

// File: rtl/ocw_pkg.sv
package ocw_pkg;

   typedef enum logic [1:0] {
      OT_FORCE_LOW = 2'b00,
      OT_PULSE_HI  = 2'b01,
      OT_PULSE_LO  = 2'b10,
      OT_TOGGLE    = 2'b11
   } otype_e;

   localparam int unsigned MIN_CNT_W = 2;
   localparam int unsigned MAX_CNT_W = 32;
   localparam int unsigned MIN_PW_W  = 1;
   localparam int unsigned MAX_PW_W  = 16;

endpackage

// File: rtl/ocw_period_ctr.sv
module ocw_period_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             hit_o,
   output logic             evt_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             at_term;
   logic             evt_q;

   assign at_term = (cnt_q >= period_i);
   assign hit_o   = en_i & tick_i & at_term;

   always_comb begin
      cnt_d = cnt_q;
      if (!en_i) begin
         cnt_d = '0;
      end else if (tick_i) begin
         if (at_term) cnt_d = '0;
         else         cnt_d = cnt_q + CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         evt_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         evt_q <= hit_o;
      end
   end

   assign evt_o = evt_q;

   AST_EVT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> $past(en_i && tick_i)); // R1
   AST_EVT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> (cnt_q == '0)); // R1
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !tick_i) |=> (cnt_q == $past(cnt_q))); // R1
   AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (cnt_q == '0 && !evt_q)); // R2

endmodule

// File: rtl/ocw_pulse_timer.sv
module ocw_pulse_timer #(
   parameter int unsigned PW_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_i,
   input  logic            hit_i,
   input  logic [PW_W-1:0] pw_i,
   output logic            act_o
);

   localparam logic [PW_W-1:0] PW_ONE = {{(PW_W-1){1'b0}}, 1'b1};

   logic [PW_W-1:0] rem_q;
   logic            act_q;
   logic            pw_zero;

   assign pw_zero = (pw_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rem_q <= '0;
      end else if (!en_i) begin
         act_q <= 1'b0;
         rem_q <= '0;
      end else if (hit_i) begin
         act_q <= !pw_zero;
         rem_q <= pw_zero ? '0 : (pw_i - PW_ONE);
      end else if (act_q) begin
         if (rem_q == '0) act_q <= 1'b0;
         else             rem_q <= rem_q - PW_ONE;
      end
   end

   assign act_o = act_q;

   AST_PW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && pw_i == '0) |=> !act_q); // R7
   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && pw_i != '0) |=> act_q); // R4
   AST_DIS_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !act_q); // R2

endmodule

// File: rtl/ocw_pin_ctl.sv
module ocw_pin_ctl
   import ocw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       hit_i,
   input  logic [1:0] otype_i,
   input  logic       act_i,
   input  logic       preset_i,
   output logic       pin_o
);

   logic   tog_q;
   otype_e mode;

   assign mode = otype_e'(otype_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tog_q <= 1'b0;
      else if (!en_i)  tog_q <= preset_i;
      else if (hit_i)  tog_q <= ~tog_q;
   end

   always_comb begin
      if (!en_i) begin
         pin_o = preset_i;
      end else begin
         unique case (mode)
            OT_FORCE_LOW: pin_o = 1'b0;
            OT_PULSE_HI:  pin_o = act_i;
            OT_PULSE_LO:  pin_o = ~act_i;
            OT_TOGGLE:    pin_o = tog_q;
            default:      pin_o = 1'b0;
         endcase
      end
   end

   AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> (tog_q != $past(tog_q))); // R9
   AST_TOG_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (tog_q == $past(preset_i))); // R9

endmodule

// File: rtl/ocw_gen.sv
module ocw_gen
   import ocw_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PW_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [1:0]       otype_i,
   input  logic [PW_W-1:0]  pwidth_i,
   input  logic             preset_i,
   output logic             evt_o,
   output logic             pin_o
);

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_cnt_w
         $error("ocw_gen: CNT_W out of range");
      end
      if (PW_W < MIN_PW_W || PW_W > MAX_PW_W) begin : g_bad_pw_w
         $error("ocw_gen: PW_W out of range");
      end
   endgenerate

   logic hit;
   logic act;

   ocw_period_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .tick_i   (tick_i),
      .period_i (period_i),
      .hit_o    (hit),
      .evt_o    (evt_o)
   );

   ocw_pulse_timer #(.PW_W(PW_W)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (en_i),
      .hit_i (hit),
      .pw_i  (pwidth_i),
      .act_o (act)
   );

   ocw_pin_ctl u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .hit_i    (hit),
      .otype_i  (otype_i),
      .act_i    (act),
      .preset_i (preset_i),
      .pin_o    (pin_o)
   );

   AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> $past(en_i)); // R2

endmodule

// File: tb/ocw_gen_bench.sv
module ocw_gen_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        tick = 1'b0;
   logic [15:0] period = 16'd0;
   logic [1:0]  otype = 2'b00;
   logic [7:0]  pw = 8'd0;
   logic        preset = 1'b0;
   logic        evt_o;
   logic        pin_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int tick_every = 1;
   int tick_pct = 100;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ocw_gen u_ocw_gen (
      .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick),
      .period_i(period), .otype_i(otype), .pwidth_i(pw),
      .preset_i(preset), .evt_o(evt_o), .pin_o(pin_o)
   );

   // reference model built from the requirements
   int m_cnt = 0;
   int m_rem = 0;
   bit m_evt = 1'b0;
   bit m_tog = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_rem = 0; m_evt = 1'b0; m_tog = 1'b0;
      end else if (!en) begin
         m_cnt = 0; m_rem = 0; m_evt = 1'b0; m_tog = preset;
      end else begin
         bit hit;
         hit = tick && (m_cnt >= int'(period));
         m_evt = hit;
         if (tick) m_cnt = hit ? 0 : m_cnt + 1;
         if (hit) begin
            m_rem = int'(pw);
            m_tog = ~m_tog;
         end else if (m_rem > 0) begin
            m_rem = m_rem - 1;
         end
      end
   end

   function automatic bit exp_pin(bit e, bit p, logic [1:0] t, int rem, bit tg);
      if (!e) return p;
      case (t)
         2'b00: return 1'b0;
         2'b01: return rem > 0;
         2'b10: return !(rem > 0);
         default: return tg;
      endcase
   endfunction

   function automatic string pin_tag(bit e, logic [1:0] t);
      if (!e) return "R2";
      case (t)
         2'b00: return "R3";
         2'b01: return "R4";
         2'b10: return "R5";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // tick driver
   always @(negedge clk) begin
      cyc++;
      if (tick_every > 0) tick <= (cyc % tick_every) == 0;
      else                tick <= ($urandom_range(0, 99) < tick_pct);
   end

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         bit ep;
         ep = exp_pin(en, preset, otype, m_rem, m_tog);
         chk(evt_o == m_evt, "R1", evt_o, m_evt);
         chk(pin_o == ep, pin_tag(en, otype), pin_o, ep);
      end
   end

   task automatic step(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic cfg(bit e, bit p, logic [1:0] t, int per, int w, int te);
      @(negedge clk);
      en = e; preset = p; otype = t; period = 16'(per); pw = 8'(w); tick_every = te;
   endtask

   task automatic wait_evt();
      int g;
      g = 0;
      step(1);
      while (!evt_o && g < 200) begin step(1); g++; end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      bit all;
      void'($urandom(32'd4711));
      preset = 1'b1;
      step(3);
      rst_n = 1'b1;
      step(1);
      // reset state, R2
      chk(evt_o == 1'b0, "R2", evt_o, 0);
      chk(pin_o == 1'b1, "R2", pin_o, 1);

      // R6: slow ticks, pulse length counted in clocks
      cfg(1, 0, 2'b01, 2, 3, 4);
      wait_evt();
      n = 0;
      while (pin_o && n < 100) begin n++; step(1); end
      chk(n == 3, "R6", n, 3);

      // R10 and R8: long pulse keeps spacing and stays active
      cfg(1, 0, 2'b01, 3, 10, 1);
      wait_evt();
      wait_evt();
      n = 1; all = 1'b1;
      step(1);
      while (!evt_o && n < 100) begin all &= pin_o; n++; step(1); end
      chk(n == 4, "R10", n, 4);
      chk(all, "R8", all, 1);

      // R5: low pulse, width 2
      cfg(1, 0, 2'b10, 5, 2, 1);
      wait_evt();
      chk(pin_o == 1'b0, "R5", pin_o, 0);
      step(2);
      chk(pin_o == 1'b1, "R5", pin_o, 1);

      // R7: zero width gives no pulse
      cfg(1, 0, 2'b01, 2, 0, 1);
      all = 1'b0; n = 0;
      repeat (20) begin step(1); all |= pin_o; n += evt_o; end
      chk(!all, "R7", all, 0);
      chk(n > 0, "R7", n, 1);

      // R3: forced low even with events and preset high
      cfg(1, 1, 2'b00, 1, 3, 1);
      all = 1'b0;
      repeat (20) begin step(1); all |= pin_o; end
      chk(!all, "R3", all, 0);

      // R9: toggle from preset 1
      cfg(0, 1, 2'b11, 4, 1, 1);
      step(3);
      cfg(1, 1, 2'b11, 4, 1, 1);
      step(1);
      chk(pin_o == 1'b1, "R9", pin_o, 1);
      wait_evt();
      chk(pin_o == 1'b0, "R9", pin_o, 0);
      wait_evt();
      chk(pin_o == 1'b1, "R9", pin_o, 1);

      // R2: disabled, preset low
      cfg(0, 0, 2'b01, 1, 3, 1);
      all = 1'b0;
      repeat (10) begin step(1); all |= pin_o | evt_o; end
      chk(!all, "R2", all, 0);

      // constrained random segments, compared per cycle with the model
      for (int s = 0; s < 40; s++) begin
         @(negedge clk);
         en = ($urandom_range(0, 9) != 0);
         preset = $urandom_range(0, 1);
         otype = 2'($urandom_range(0, 3));
         period = 16'($urandom_range(0, 7));
         pw = 8'($urandom_range(0, 12));
         tick_pct = $urandom_range(20, 100);
         tick_every = ($urandom_range(0, 3) == 0) ? 1 : 0;
         step($urandom_range(50, 250));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule